// File: doc/BRIEF.md
# Transmit-Data Dominant Timeout Guard

This block sits between a controller's transmit-data line and the enable of a single-wire bus low-side driver. A low on the transmit line asks for the dominant bus state and a high asks for the recessive state. The guard passes that request on to the driver, but it refuses to let a stuck-low transmit line hold the bus dominant for ever. Once the line has stayed low for the dominant timeout, the driver is forced off. It stays off until the line has been seen high for a minimum arming time.

The same arming rule applies each time the transceiver enters normal mode. A transmit line that is already low when normal mode starts cannot reach the bus until it has first gone high for the arming time. Supply-undervoltage and overtemperature flags switch the driver off at once for as long as they are set. All timing is counted in ticks of a 1 MHz enable, and the transmit line is resynchronised to the block clock before any counting starts. A status output reports that a dominant timeout is in force.

Top module: `txd_dom_guard`

## Requirements
- R1: While the guard is armed in normal mode with both fault flags clear, `drv_en` is 1 exactly when the synchronised transmit input is low; the synchronizer adds SYNC_STAGES (default 2) clock cycles of latency from `txd_in` to `drv_en`.
- R2: If the synchronised transmit input stays low while armed for TIMEOUT_TICKS ticks (default 55 000), `drv_en` goes to 0 and `timeout_act` goes to 1.
- R3: After a timeout, `drv_en` stays 0 until the transmit input has been high for ARM_TICKS consecutive ticks (default 11); a high spell shorter than that, followed by a low, does not re-arm, and a low after re-arming drives the bus again.
- R4: After `normal_mode` rises, `drv_en` stays 0 until the transmit input has been high for ARM_TICKS consecutive ticks; a transmit input held low from mode entry onward never sets `drv_en`.
- R5: While `uv_flag` is 1, `drv_en` is 0 in the same cycle; the flag does not disarm the guard, so clearing it with the guard armed and the input low sets `drv_en` again in the same cycle.
- R6: While `ot_flag` is 1, `drv_en` is 0 in the same cycle; clearing it with the guard armed and the input low sets `drv_en` again in the same cycle.
- R7: `timeout_act` falls in the same cycle the guard re-arms, after ARM_TICKS or ARM_TICKS+1 observed ticks of high input; dropping `normal_mode` clears `timeout_act` and disarms the guard.
- R8: After reset, `drv_en` and `timeout_act` are both 0.
- R9: Low spells shorter than TIMEOUT_TICKS, separated by any high, never cause a timeout: the dominant count restarts on every high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle enable pulse at 1 MHz |
| txd_in | input | 1 | Transmit data from the controller, 0 = dominant request |
| normal_mode | input | 1 | 1 while the transceiver is in normal mode |
| uv_flag | input | 1 | Supply undervoltage, 1 = transmission disabled |
| ot_flag | input | 1 | Overtemperature, 1 = driver switched off |
| drv_en | output | 1 | Low-side driver enable, 1 = pull bus dominant |
| timeout_act | output | 1 | 1 while a dominant timeout holds the driver off |

## Verification
If the arming state goes wrong, `drv_en` rises on a low input that entered normal mode low or that has just timed out. This shows within one tick of the low. If the dominant counter is wrong, the trip moves away from TIMEOUT_TICKS, or short low pulses trip it. The bench sees either as `drv_en` or `timeout_act` being wrong a few ticks either side of the nominal limit. A re-arm counter that counts too few or too many ticks shows up as the tick at which `timeout_act` falls. Flag gating errors show in the same cycle the flag changes.

// File: rtl/txg_pkg.sv
package txg_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARMED = 2'd2,
    ST_TMO   = 2'd3
  } txg_state_e;

  // Bits needed to hold values 0 .. limit-1
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // True when one more tick completes a window of length limit
  function automatic logic at_last(input logic [31:0] cnt, input int unsigned limit);
    return (cnt + 32'd1) >= limit;
  endfunction

endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= RESET_VAL;
        end else if (g == 0) begin
          chain_q[g] <= d_in;
        end else begin
          chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/txg_run_counter.sv
module txg_run_counter #(
  parameter int unsigned LIMIT = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic hit
);

  import txg_pkg::*;

  localparam int unsigned W = cnt_width(LIMIT);

  logic [W-1:0] cnt_q;

  assign hit = run && tick && at_last(32'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || hit) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < LIMIT); // R2

  AST_CNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/txg_arm_fsm.sv
module txg_arm_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                normal_mode,
  input  logic                txd_s,
  input  logic                dom_hit,
  input  logic                arm_hit,
  output txg_pkg::txg_state_e state,
  output logic                dom_run,
  output logic                arm_run
);

  import txg_pkg::*;

  txg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!normal_mode) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   state_d = ST_WAIT;
        ST_WAIT:  if (arm_hit) state_d = ST_ARMED;
        ST_ARMED: if (dom_hit) state_d = ST_TMO;
        ST_TMO:   if (arm_hit) state_d = ST_ARMED;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign dom_run = normal_mode && (state_q == ST_ARMED) && !txd_s;
  assign arm_run = normal_mode && ((state_q == ST_WAIT) || (state_q == ST_TMO)) && txd_s;

  AST_ARM_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED) && ($past(state_q) != ST_ARMED) |-> $past(txd_s)); // R3

  AST_TMO_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_TMO) |-> ($past(state_q) == ST_ARMED) && $past(dom_hit)); // R2

  AST_TMO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_TMO) && (state_q != ST_TMO)
      |-> ((state_q == ST_ARMED) == $past(normal_mode))); // R7

  AST_OFF_OUTSIDE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode |=> (state_q == ST_OFF)); // R7

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned TIMEOUT_TICKS = 55000,
  parameter int unsigned ARM_TICKS     = 11,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1us,
  input  logic txd_in,
  input  logic normal_mode,
  input  logic uv_flag,
  input  logic ot_flag,
  output logic drv_en,
  output logic timeout_act
);

  import txg_pkg::*;

  logic       txd_s;
  logic       dom_run, arm_run;
  logic       dom_hit, arm_hit;
  logic       fault_block;
  txg_state_e state;

  txg_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (txd_in),
    .d_out(txd_s)
  );

  txg_run_counter #(.LIMIT(TIMEOUT_TICKS)) u_dom_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_1us),
    .run  (dom_run),
    .hit  (dom_hit)
  );

  txg_run_counter #(.LIMIT(ARM_TICKS)) u_arm_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_1us),
    .run  (arm_run),
    .hit  (arm_hit)
  );

  txg_arm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .normal_mode(normal_mode),
    .txd_s      (txd_s),
    .dom_hit    (dom_hit),
    .arm_hit    (arm_hit),
    .state      (state),
    .dom_run    (dom_run),
    .arm_run    (arm_run)
  );

  assign fault_block = uv_flag || ot_flag;
  assign drv_en      = (state == ST_ARMED) && !txd_s && !fault_block;
  assign timeout_act = (state == ST_TMO);

  AST_DRIVE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> !$past(txd_in, 2)); // R1

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag || ot_flag) |-> !drv_en); // R5

  AST_TMO_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_act |-> !drv_en); // R3

  AST_ENTRY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(normal_mode) |-> !drv_en ##1 !drv_en); // R4

endmodule

// File: tb/txd_dom_guard_bench.sv
module txd_dom_guard_bench;

  localparam int unsigned TMO  = 200;
  localparam int unsigned ARM  = 11;
  localparam int unsigned TDIV = 4;
  localparam int unsigned WD   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic txd = 1'b1;
  logic nm = 1'b0;
  logic uv = 1'b0;
  logic ot = 1'b0;
  logic drv_en, timeout_act;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  txd_dom_guard #(
    .TIMEOUT_TICKS(TMO),
    .ARM_TICKS    (ARM),
    .SYNC_STAGES  (2)
  ) u_txd_dom_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1us   (tick),
    .txd_in     (txd),
    .normal_mode(nm),
    .uv_flag    (uv),
    .ot_flag    (ot),
    .drv_en     (drv_en),
    .timeout_act(timeout_act)
  );

  initial begin
    forever begin
      repeat (TDIV-1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (tick !== 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_armed();
    nm = 1'b0; txd = 1'b1;
    wait_clks(2);
    nm = 1'b1;
    wait_ticks(ARM + 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_clks(3);
    check("R8", "drv_en in reset", drv_en, 1'b0);
    check("R8", "timeout_act in reset", timeout_act, 1'b0);
    rst_n = 1'b1;
    wait_clks(3);
    check("R8", "drv_en after reset", drv_en, 1'b0);
    check("R8", "timeout_act after reset", timeout_act, 1'b0);
  endtask

  task automatic t_entry();
    nm = 1'b0; txd = 1'b0;
    wait_clks(3);
    nm = 1'b1;
    wait_ticks(50);
    check("R4", "low held from entry", drv_en, 1'b0);
    txd = 1'b1;
    wait_ticks(ARM - 4);
    txd = 1'b0;
    wait_clks(3);
    check("R4", "short high at entry does not arm", drv_en, 1'b0);
    txd = 1'b1;
    wait_ticks(ARM + 3);
    txd = 1'b0;
    wait_clks(3);
    check("R4", "armed after full high", drv_en, 1'b1);
    txd = 1'b1;
    wait_clks(1);
  endtask

  task automatic t_drive();
    enter_armed();
    txd = 1'b0;
    wait_clks(1);
    check("R1", "one clock into sync", drv_en, 1'b0);
    wait_clks(1);
    check("R1", "low after two clocks", drv_en, 1'b1);
    txd = 1'b1;
    wait_clks(2);
    check("R1", "high after two clocks", drv_en, 1'b0);
    txd = 1'b0;
    wait_clks(2);
    check("R1", "low again", drv_en, 1'b1);
    txd = 1'b1;
    wait_clks(2);
  endtask

  task automatic t_timeout();
    int n;
    int guard;
    enter_armed();
    txd = 1'b0;
    wait_ticks(TMO - 3);
    check("R2", "still driving before limit", drv_en, 1'b1);
    check("R2", "no status before limit", timeout_act, 1'b0);
    wait_ticks(6);
    check("R2", "driver off after limit", drv_en, 1'b0);
    check("R2", "status after limit", timeout_act, 1'b1);
    txd = 1'b1;
    wait_ticks(ARM - 4);
    txd = 1'b0;
    wait_clks(3);
    check("R3", "short high keeps driver off", drv_en, 1'b0);
    check("R3", "short high keeps status", timeout_act, 1'b1);
    txd = 1'b1;
    n = 0;
    guard = 0;
    while (timeout_act === 1'b1 && guard < 2000) begin
      @(posedge clk);
      if (tick === 1'b1) n++;
      @(negedge clk);
      guard++;
    end
    check("R7", "status clear tick count in window",
          (n >= int'(ARM)) && (n <= int'(ARM) + 1), 1'b1);
    txd = 1'b0;
    wait_clks(2);
    check("R3", "drives after re-arm", drv_en, 1'b1);
    txd = 1'b1;
    wait_clks(2);
  endtask

  task automatic t_leave();
    enter_armed();
    txd = 1'b0;
    wait_ticks(TMO + 3);
    check("R7", "timeout reached", timeout_act, 1'b1);
    nm = 1'b0;
    wait_clks(1);
    check("R7", "status cleared on leaving normal", timeout_act, 1'b0);
    nm = 1'b1;
    wait_ticks(20);
    check("R7", "disarmed after re-entry with low", drv_en, 1'b0);
    txd = 1'b1;
    wait_clks(2);
  endtask

  task automatic t_short_pulses();
    enter_armed();
    for (int p = 0; p < 3; p++) begin
      txd = 1'b0;
      wait_ticks(TMO - 20);
      check("R9", "pulse below limit drives", drv_en, 1'b1);
      txd = 1'b1;
      wait_ticks(2);
    end
    check("R9", "no timeout from short pulses", timeout_act, 1'b0);
  endtask

  task automatic t_flags();
    enter_armed();
    txd = 1'b0;
    wait_clks(3);
    uv = 1'b1;
    #1;
    check("R5", "undervoltage blocks", drv_en, 1'b0);
    wait_ticks(3);
    check("R5", "still blocked", drv_en, 1'b0);
    uv = 1'b0;
    #1;
    check("R5", "undervoltage clear drives", drv_en, 1'b1);
    ot = 1'b1;
    #1;
    check("R6", "overtemperature blocks", drv_en, 1'b0);
    ot = 1'b0;
    #1;
    check("R6", "overtemperature clear drives", drv_en, 1'b1);
    @(negedge clk);
    txd = 1'b1;
    wait_clks(2);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_drive();
    t_timeout();
    t_leave();
    t_short_pulses();
    t_flags();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule